// File: doc/BRIEF.md
# Oversampled Bit Clock Recovery

This block recovers a bit-rate strobe from a serial data line. It divides the system clock down to an oversampling tick that runs sixteen times per bit and counts those ticks in a phase counter. The block raises a one-cycle strobe, together with the sampled data bit, each time the phase passes the middle of the bit. Edges on the synchronised input are measured against the expected bit boundary, which is phase 0. Each edge moves the phase by at most one tick, so the strobe settles on the averaged centre of the bit and does not jump to every edge.

A preamble detector starts the block through `arm`. Arm restarts the divider and the phase counter, so the first strobe falls half a bit later, and it enters a training phase. During training every off-centre edge corrects the phase. After a set number of edges the block moves to tracking. In tracking a correction needs two consecutive errors in the same direction, which filters edge jitter. The rate code is read only while reset is held.

FSM states: `ST_IDLE`, which produces no strobes and waits for arm. `ST_TRAIN`, in which every edge corrects the phase. `ST_TRACK`, in which corrections are filtered. Transitions: IDLE→TRAIN on arm. TRAIN→TRAIN on arm, which restarts the block. TRAIN→TRACK on the edge that completes `TRAIN_EDGES` edges. TRACK→TRAIN on arm. Only reset returns the block to IDLE.

Top module: `bit_clock_recovery`

## Requirements
- R1: After reset `strobe_o` and `data_bit_o` are 0, and no strobe is produced until `arm` has been sampled high.
- R2: `rate_sel` is captured on every clock edge while `rst` is high and is ignored after that. A change made after reset leaves the strobe timing unchanged.
- R3: The tick period D is `BASE_DIV` × 8, 4, 2 or 1 clock cycles for `rate_sel` values 2'b00, 2'b01, 2'b10 and 2'b11, where bit 1 is the high-order bit of the code. One bit period is 16 ticks.
- R4: If no input edge occurs, the first strobe after arm is visible in the cycle after the 8·D-th clock edge that follows the edge sampling `arm`.
- R5: If no input edge occurs, strobes repeat every 16·D cycles for as long as the block runs.
- R6: `strobe_o` is high for exactly one cycle at a time.
- R7: On each strobe `data_bit_o` takes the input value after a two-flop synchroniser, and it holds that value between strobes.
- R8: In training, each edge on the synchronised input is graded by the current phase. Phase 1..7 means the edge is late and the next tick advances the phase by 0. Phase 8..15 means the edge is early and the next tick advances it by 2. Phase 0 means no correction. Training ends on the `TRAIN_EDGES`-th edge.
- R9: In tracking, a correction is scheduled only when an error has the same direction as the previous error. A scheduled correction clears that memory, and so does a centred edge.
- R10: Arm sampled high while the block is running restarts the divider, the phase and training.
- R11: The phase advances by 0, 1 or 2 per tick and never moves between ticks. A strobe occurs when a tick takes the phase from below 8 to 8 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the rate code is captured while it is high |
| din | input | 1 | Serial data line, asynchronous |
| rate_sel | input | 2 | Bit-rate code |
| arm | input | 1 | Start pulse from the preamble detector |
| strobe_o | output | 1 | One-cycle data-valid strobe at mid-bit |
| data_bit_o | output | 1 | Sampled data bit, updated on each strobe |

## Verification
An input level reaches the edge detector two clock edges after it is driven. The detector's correction applies at the next tick. A strobe becomes visible in the cycle after the tick edge that crosses mid-bit, and the data bit becomes visible with it. The bench drives inputs on the falling clock edge. A behavioural model advances on each rising edge using the same latency counts, and it is compared with both outputs at every falling edge. Directed checks count falling edges from the arm edge to the first strobe, which is expected after 8·D edges, and then between strobes, which is expected after 16·D edges, for each rate code.

// File: rtl/brc_pkg.sv
package brc_pkg;
    localparam int RATE_W    = 2;
    localparam int MAX_SHIFT = (1 << RATE_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_TRACK = 2'd2
    } brc_state_t;
endpackage

// File: rtl/brc_tick_gen.sv
module brc_tick_gen
    import brc_pkg::*;
#(
    parameter int BASE_DIV = 407
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              restart,
    output logic              tick_o
);
    localparam int DIV_W = $clog2((BASE_DIV << MAX_SHIFT) + 1);

    logic [RATE_W-1:0] rate_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  lim;

    always_ff @(posedge clk) begin
        if (rst) rate_q <= rate_sel;
    end

    always_comb lim = DIV_W'((BASE_DIV << (MAX_SHIFT - int'(rate_q))) - 1);
    assign tick_o = (div_q == lim);

    always_ff @(posedge clk) begin
        if (rst || restart) div_q <= '0;
        else if (tick_o)    div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    // R2
    rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(rate_q));
endmodule

// File: rtl/brc_in_sync.sv
module brc_in_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic bit_o,
    output logic edge_o
);
    logic s1_q, s2_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            last_q <= 1'b0;
        end else begin
            s1_q   <= din;
            s2_q   <= s1_q;
            last_q <= s2_q;
        end
    end

    assign bit_o  = s2_q;
    assign edge_o = s2_q ^ last_q;
endmodule

// File: rtl/brc_phase_track.sv
module brc_phase_track #(
    parameter int OSR       = 16,
    parameter int STROBE_PT = OSR / 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic edge_i,
    input  logic run,
    input  logic track,
    output logic hit_o
);
    localparam int PH_W = $clog2(OSR);
    localparam int HALF = OSR / 2;

    logic [PH_W-1:0] ph_q;
    logic [PH_W:0]   adv;
    logic [1:0]      pend_q, pend_n;   // 00 none, 01 advance extra, 11 hold
    logic [1:0]      lean_q, lean_n;   // same code: direction of last error
    logic [1:0]      err_dir;          // 01 early edge, 11 late edge, 00 centred

    always_comb begin
        unique case (pend_q)
            2'b01:   adv = {1'b0, ph_q} + (PH_W+1)'(2);
            2'b11:   adv = {1'b0, ph_q};
            default: adv = {1'b0, ph_q} + (PH_W+1)'(1);
        endcase
    end

    assign hit_o = tick && run && (int'(ph_q) < STROBE_PT) && (int'(adv) >= STROBE_PT);

    always_comb begin
        if (ph_q == '0)              err_dir = 2'b00;
        else if (int'(ph_q) < HALF)  err_dir = 2'b11;
        else                         err_dir = 2'b01;
    end

    always_comb begin
        pend_n = tick ? 2'b00 : pend_q;
        lean_n = lean_q;
        if (edge_i && run) begin
            if (!track) begin
                pend_n = err_dir;
                lean_n = 2'b00;
            end else if (err_dir == 2'b00) begin
                lean_n = 2'b00;
            end else if (lean_q == err_dir) begin
                pend_n = err_dir;
                lean_n = 2'b00;
            end else begin
                lean_n = err_dir;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ph_q   <= '0;
            pend_q <= 2'b00;
            lean_q <= 2'b00;
        end else begin
            if (tick) ph_q <= (int'(adv) >= OSR) ? PH_W'(int'(adv) - OSR) : PH_W'(adv);
            pend_q <= pend_n;
            lean_q <= lean_n;
        end
    end

    // R11
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> (PH_W'(ph_q - $past(ph_q)) <= PH_W'(2)));
    // R11
    phase_still_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(ph_q));
endmodule

// File: rtl/bit_clock_recovery.sv
module bit_clock_recovery
    import brc_pkg::*;
#(
    parameter int BASE_DIV    = 407,
    parameter int OSR         = 16,
    parameter int TRAIN_EDGES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic [1:0] rate_sel,
    input  logic       arm,
    output logic       strobe_o,
    output logic       data_bit_o
);
    localparam int CNT_W = $clog2(TRAIN_EDGES + 1);

    brc_state_t state_q, state_n;
    logic [CNT_W-1:0] edges_q;
    logic tick, sbit, sedge, hit;
    logic strobe_q, data_q;

    brc_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .restart(arm), .tick_o(tick));

    brc_in_sync u_sync (
        .clk(clk), .rst(rst), .din(din), .bit_o(sbit), .edge_o(sedge));

    brc_phase_track #(.OSR(OSR)) u_phase (
        .clk(clk), .rst(rst), .clr(arm), .tick(tick), .edge_i(sedge),
        .run(state_q != ST_IDLE), .track(state_q == ST_TRACK), .hit_o(hit));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm) state_n = ST_TRAIN;
            ST_TRAIN: if (arm) state_n = ST_TRAIN;
                      else if (sedge && int'(edges_q) == TRAIN_EDGES - 1) state_n = ST_TRACK;
            ST_TRACK: if (arm) state_n = ST_TRAIN;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || arm)                        edges_q <= '0;
        else if (state_q == ST_TRAIN && sedge) edges_q <= edges_q + 1'b1;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            data_q   <= 1'b0;
        end else if (arm) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= hit;
            if (hit) data_q <= sbit;
        end
    end

    assign strobe_o   = strobe_q;
    assign data_bit_o = data_q;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !strobe_o);
    // R6
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);
    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_o |-> $stable(data_bit_o));
    // R9
    track_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRACK) |-> ($past(state_q) != ST_IDLE));
endmodule

// File: tb/bit_clock_recovery_tb_top.sv
module bit_clock_recovery_tb_top;
    localparam int BD = 2;
    localparam int TE = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic arm = 1'b0;
    logic strobe_o, data_bit_o;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    logic started = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    bit_clock_recovery #(.BASE_DIV(BD), .OSR(16), .TRAIN_EDGES(TE)) dut_i (
        .clk(clk), .rst(rst), .din(din), .rate_sel(rate_sel), .arm(arm),
        .strobe_o(strobe_o), .data_bit_o(data_bit_o));

    // behavioural reference model
    int m_rate, m_s1, m_s2, m_d, m_div, m_ph, m_st, m_cnt, m_pend, m_lean, m_strb, m_bit;
    always @(posedge clk) begin
        int per, tk, ed, nph, npend, nlean, nst, ncnt, nstrb, nbit, adv, err, sg;
        started <= 1'b1;
        if (rst) begin
            m_rate = rate_sel; m_s1 = 0; m_s2 = 0; m_d = 0; m_div = 0; m_ph = 0;
            m_st = 0; m_cnt = 0; m_pend = 0; m_lean = 0; m_strb = 0; m_bit = 0;
        end else begin
            per = BD << (3 - m_rate);
            tk = (m_div == per - 1);
            ed = (m_s2 != m_d);
            nstrb = 0; nbit = m_bit;
            if (arm) begin
                m_div = 0; m_ph = 0; m_st = 1; m_cnt = 0; m_pend = 0; m_lean = 0;
            end else begin
                nph = m_ph; npend = m_pend; nlean = m_lean; nst = m_st; ncnt = m_cnt;
                if (tk) begin
                    adv = m_ph + 1 + m_pend;
                    if (m_st != 0 && m_ph < 8 && adv >= 8) begin nstrb = 1; nbit = m_s2; end
                    nph = adv % 16;
                    npend = 0;
                end
                if (ed && m_st != 0) begin
                    err = (m_ph < 8) ? m_ph : m_ph - 16;
                    sg = (err > 0) ? 1 : (err < 0) ? -1 : 0;
                    if (m_st == 1) begin
                        npend = -sg; nlean = 0; ncnt = m_cnt + 1;
                        if (m_cnt == TE - 1) nst = 2;
                    end else if (sg == 0) nlean = 0;
                    else if (m_lean == sg) begin npend = -sg; nlean = 0; end
                    else nlean = sg;
                end
                m_div = tk ? 0 : m_div + 1;
                m_ph = nph; m_pend = npend; m_lean = nlean; m_st = nst; m_cnt = ncnt;
            end
            m_strb = nstrb; m_bit = nbit;
            m_d = m_s2; m_s2 = m_s1; m_s1 = din;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp++;
            if (strobe_o !== m_strb[0] || data_bit_o !== m_bit[0]) begin
                n_bad++;
                $display("FAIL %s: strobe=%0b data=%0b expected strobe=%0b data=%0b",
                         cur_req, strobe_o, data_bit_o, m_strb[0], m_bit[0]);
            end
        end
    end

    task automatic check_eq(string r, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic do_reset(int code);
        @(negedge clk);
        rst = 1'b1; rate_sel = 2'(code);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic wait_strobe(output int n, input int limit);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!strobe_o && n < limit);
    endtask

    task automatic hold(logic v, int cycles);
        din = v;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        int n, seen, d;
        logic [7:0] lfsr;
        do_reset(0);
        // R1: reset values, then idle with activity on the line
        check_eq("R1 strobe after reset", int'(strobe_o), 0);
        check_eq("R1 data after reset", int'(data_bit_o), 0);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            din = (i % 23) < 11;
            @(negedge clk);
            if (strobe_o) seen++;
        end
        check_eq("R1 strobes while idle", seen, 0);
        din = 1'b0;

        // R3 R4 R5: each rate code, quiet line
        for (int code = 0; code < 4; code++) begin
            cur_req = "R3 R4 R5";
            do_reset(code);
            repeat (5) @(negedge clk);
            d = BD << (3 - code);
            pulse_arm();
            wait_strobe(n, 40 * d);
            check_eq("R4 R3 first strobe delay", n, 8 * d);
            for (int k = 0; k < 2; k++) begin
                wait_strobe(n, 40 * d);
                check_eq("R5 R3 strobe spacing", n, 16 * d);
            end
        end

        // R2: rate change after reset has no effect
        cur_req = "R2";
        do_reset(3);
        rate_sel = 2'b00;
        pulse_arm();
        wait_strobe(n, 400);
        check_eq("R2 first strobe delay with late rate change", n, 16);
        wait_strobe(n, 400);
        check_eq("R2 spacing with late rate change", n, 32);

        // R10: re-arm mid-bit
        cur_req = "R10";
        repeat (37) @(negedge clk);
        pulse_arm();
        wait_strobe(n, 400);
        check_eq("R10 first strobe after re-arm", n, 16);

        // R8 R11 R6: training on alternating preamble with slow drift
        cur_req = "R8 R11 R6";
        do_reset(3);
        hold(1'b0, 64);
        arm = 1'b1; din = 1'b1;
        @(negedge clk); arm = 1'b0;
        repeat (31) @(negedge clk);
        for (int b = 0; b < 9; b++) hold(b[0], 35);

        // R9 R7: payload with edge jitter
        cur_req = "R9 R7";
        lfsr = 8'hA5;
        for (int b = 0; b < 48; b++) begin
            hold(lfsr[0], (b % 2 == 0) ? 30 : 34);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        // R9: single late edges do not move the phase on their own
        for (int b = 0; b < 6; b++) hold(b[0], (b % 3 == 0) ? 35 : 32);

        // R5: quiet line keeps strobing
        cur_req = "R5";
        seen = 0;
        din = 1'b0;
        for (int i = 0; i < 640; i++) begin
            @(negedge clk);
            if (strobe_o) seen++;
        end
        check_eq("R5 strobes over 20 bit periods", seen, 20);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule